// File: doc/BRIEF.md
# Row Dispatcher with Priority Result Collector

This block sits between a pool of row workers and a single result sink. Each worker raises a request line while it is idle. In any cycle the dispatcher grants at most one worker: the requesting worker with the lowest index. The grant is combinational on the request. On that same cycle the dispatcher presents a row number and that row's imaginary coordinate to every worker, and the granted worker latches them. At the next clock edge the dispatcher moves on to the following row. The coordinate is built by repeated addition of a step value, starting from a top-left value. After the last row of a frame the row number wraps to zero, the coordinate restarts, and a one-cycle frame-done pulse is produced.

Workers return results as strobed records holding a row, a column and a value. Each worker has its own small queue. A second lowest-index arbiter drains one queued record per cycle onto a single output port that carries a strobe. A record that arrives at a full queue is discarded, and the worker's overflow flag is set and stays set until reset. All logic runs on one clock. The external reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `row_dispatch`

## Requirements
- R1: While reset is active, and at the first check after release, the outputs read as follows: `row_idx` is 0, `row_coord` equals `top_left`, `frame_done` is 0, `out_stb` is 0 and `overflow` is all zero.
- R2: `wkr_grant` has at most one bit set. It is combinational on `wkr_req` and selects the lowest-indexed set request bit. It is zero when no request is set.
- R3: When a grant is issued and `row_idx` is below ROWS-1, `row_idx` rises by 1 at the next edge and `row_coord` rises by `step` (two's complement, modulo 2^27). In a cycle with no grant, both outputs hold their values.
- R4: When a grant is issued while `row_idx` equals ROWS-1 (479 by default), the following happens after the next edge: `row_idx` is 0, `row_coord` equals `top_left`, and `frame_done` is high for exactly that one cycle.
- R5: A high `res_stb[i]` queues the record {row, column, value} taken from worker i's slices. The record is 9, 10 and 16 bits wide, with worker i's fields at bit offsets i*9, i*10 and i*16 of `res_row`, `res_col` and `res_val`. If that queue was empty and no lower-indexed queue holds data, the record appears on `out_row`/`out_col`/`out_val` with `out_stb` high in the cycle after the strobe.
- R6: Each cycle, the lowest-indexed non-empty queue presents its oldest record on the output and is popped at the next edge. The records of one worker leave in the order they arrived.
- R7: `out_stb` is high only in cycles that deliver a record. When it is low, `out_row`, `out_col` and `out_val` are zero.
- R8: Each queue holds 4 records. Fullness is judged before any pop in the same cycle. A strobe that arrives while the queue is full is dropped, and the strobe sets `overflow[i]`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| top_left | input | 27 | Imaginary coordinate of row 0 |
| step | input | 27 | Coordinate increment per row |
| wkr_req | input | N | Idle request per worker |
| wkr_grant | output | N | One-hot-or-zero row grant |
| row_idx | output | 9 | Row handed out with a grant |
| row_coord | output | 27 | Coordinate handed out with a grant |
| frame_done | output | 1 | One-cycle pulse after the last row is granted |
| res_stb | input | N | Result strobe per worker |
| res_row | input | N*9 | Result row per worker |
| res_col | input | N*10 | Result column per worker |
| res_val | input | N*16 | Result value per worker |
| out_stb | output | 1 | Output record valid |
| out_row | output | 9 | Output record row |
| out_col | output | 10 | Output record column |
| out_val | output | 16 | Output record value |
| overflow | output | N | Sticky dropped-record flag per worker |

## Verification
The grant is combinational, so the bench checks it a short delay after it changes `wkr_req`, with no clock edge in between. Row number, coordinate and frame-done are registered one edge behind the grant, and the bench samples them 1 ns after that edge against its own row/coordinate model. A result strobe reaches the output one edge later and is checked in that cycle. Each further record in the queue appears one edge after the previous one. The bench sequences the drain checks one edge apart to show the drain order and which records the full queue discarded.

// File: rtl/rowdisp_pkg.sv
package rowdisp_pkg;
  localparam int ROW_W = 9;
  localparam int COL_W = 10;
  localparam int VAL_W = 16;
  localparam int CRD_W = 27;
  localparam int RES_W = ROW_W + COL_W + VAL_W;

  typedef struct packed {
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [VAL_W-1:0] val;
  } res_t;
endpackage

// File: rtl/rowdisp_pick.sv
// Lowest-index fixed-priority picker: one-hot or zero grant.
module rowdisp_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt = N'(1) << i;
    end
  end
endmodule

// File: rtl/rowdisp_fifo.sv
// Small synchronous queue; DEPTH must be a power of two.
module rowdisp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         ovf
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [AW:0]   cnt_q, cnt_n;
  logic          ovf_q, ovf_n;
  logic          full, accept, take;

  assign full   = (cnt_q == (AW+1)'(DEPTH));
  assign empty  = (cnt_q == '0);
  assign accept = push && !full;
  assign take   = pop && !empty;

  always_comb begin
    wr_n  = accept ? wr_q + 1'b1 : wr_q;
    rd_n  = take ? rd_q + 1'b1 : rd_q;
    cnt_n = cnt_q + (AW+1)'(accept) - (AW+1)'(take);
    ovf_n = ovf_q | (push & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_q] <= din;
  end

  assign dout = mem[rd_q];
  assign ovf  = ovf_q;
endmodule

// File: rtl/rowdisp_seq.sv
// Row number and coordinate sequencer with frame wrap.
module rowdisp_seq
  import rowdisp_pkg::*;
#(
  parameter int ROWS = 480
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CRD_W-1:0] top_left,
  input  logic [CRD_W-1:0] step,
  output logic [ROW_W-1:0] row_idx,
  output logic [CRD_W-1:0] row_coord,
  output logic             frame_done
);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] idx_q, idx_n;
  logic [CRD_W-1:0] acc_q, acc_n;
  logic             fresh_q, fresh_n;  // coordinate equals top_left
  logic             fd_q, fd_n;
  logic [CRD_W-1:0] cur;

  assign cur = fresh_q ? top_left : acc_q;

  always_comb begin
    idx_n   = idx_q;
    acc_n   = acc_q;
    fresh_n = fresh_q;
    fd_n    = 1'b0;
    if (adv) begin
      if (idx_q == LAST) begin
        idx_n   = '0;
        fresh_n = 1'b1;
        fd_n    = 1'b1;
      end else begin
        idx_n   = idx_q + 1'b1;
        acc_n   = cur + step;
        fresh_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      acc_q   <= '0;
      fresh_q <= 1'b1;
      fd_q    <= 1'b0;
    end else begin
      idx_q   <= idx_n;
      acc_q   <= acc_n;
      fresh_q <= fresh_n;
      fd_q    <= fd_n;
    end
  end

  assign row_idx    = idx_q;
  assign row_coord  = cur;
  assign frame_done = fd_q;
endmodule

// File: rtl/row_dispatch.sv
module row_dispatch
  import rowdisp_pkg::*;
#(
  parameter int N     = 4,
  parameter int ROWS  = 480,
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CRD_W-1:0]   top_left,
  input  logic [CRD_W-1:0]   step,
  input  logic [N-1:0]       wkr_req,
  output logic [N-1:0]       wkr_grant,
  output logic [ROW_W-1:0]   row_idx,
  output logic [CRD_W-1:0]   row_coord,
  output logic               frame_done,
  input  logic [N-1:0]       res_stb,
  input  logic [N*ROW_W-1:0] res_row,
  input  logic [N*COL_W-1:0] res_col,
  input  logic [N*VAL_W-1:0] res_val,
  output logic               out_stb,
  output logic [ROW_W-1:0]   out_row,
  output logic [COL_W-1:0]   out_col,
  output logic [VAL_W-1:0]   out_val,
  output logic [N-1:0]       overflow
);
  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // Dispatch side
  rowdisp_pick #(.N(N)) u_gpick (.req(wkr_req), .gnt(wkr_grant));

  rowdisp_seq #(.ROWS(ROWS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .adv        (|wkr_grant),
    .top_left   (top_left),
    .step       (step),
    .row_idx    (row_idx),
    .row_coord  (row_coord),
    .frame_done (frame_done)
  );

  // Collection side
  logic [N-1:0] nonempty, drain;
  res_t         head [N];
  res_t         sel;

  for (genvar i = 0; i < N; i++) begin : g_q
    res_t       rec;
    logic [RES_W-1:0] dout;
    logic       emp;

    assign rec.row = res_row[i*ROW_W +: ROW_W];
    assign rec.col = res_col[i*COL_W +: COL_W];
    assign rec.val = res_val[i*VAL_W +: VAL_W];

    rowdisp_fifo #(.W(RES_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_int_n),
      .push  (res_stb[i]),
      .din   (rec),
      .pop   (drain[i]),
      .dout  (dout),
      .empty (emp),
      .ovf   (overflow[i])
    );

    assign head[i]     = res_t'(dout);
    assign nonempty[i] = !emp;
  end

  rowdisp_pick #(.N(N)) u_dpick (.req(nonempty), .gnt(drain));

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++) begin
      sel = sel | (head[i] & {RES_W{drain[i]}});
    end
  end

  assign out_stb = |drain;
  assign out_row = sel.row;
  assign out_col = sel.col;
  assign out_val = sel.val;
endmodule

// File: rtl/rowdisp_chk.sv
module rowdisp_chk
  import rowdisp_pkg::*;
#(
  parameter int N    = 4,
  parameter int ROWS = 480
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CRD_W-1:0] top_left,
  input logic [CRD_W-1:0] step,
  input logic [N-1:0]     wkr_req,
  input logic [N-1:0]     wkr_grant,
  input logic [ROW_W-1:0] row_idx,
  input logic [CRD_W-1:0] row_coord,
  input logic             frame_done,
  input logic             out_stb,
  input logic [ROW_W-1:0] out_row,
  input logic [COL_W-1:0] out_col,
  input logic [VAL_W-1:0] out_val,
  input logic [N-1:0]     overflow
);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wkr_grant));
  a_r2_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (wkr_grant & ~wkr_req) == '0);
  a_r2_served: assert property (@(posedge clk) disable iff (!rst_n)
    (|wkr_req) |-> (|wkr_grant));
  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wkr_grant) && row_idx != LAST) |=> row_idx == ROW_W'($past(row_idx) + 1'b1));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wkr_grant) |=> ($stable(row_idx) && !frame_done));
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wkr_grant) && row_idx == LAST) |=> (row_idx == '0 && frame_done));
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (row_coord == top_left));
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_stb |-> (out_row == '0 && out_col == '0 && out_val == '0));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|overflow) |=> ((overflow & $past(overflow)) == $past(overflow)));
endmodule

bind row_dispatch rowdisp_chk #(.N(N), .ROWS(ROWS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .top_left   (top_left),
  .step       (step),
  .wkr_req    (wkr_req),
  .wkr_grant  (wkr_grant),
  .row_idx    (row_idx),
  .row_coord  (row_coord),
  .frame_done (frame_done),
  .out_stb    (out_stb),
  .out_row    (out_row),
  .out_col    (out_col),
  .out_val    (out_val),
  .overflow   (overflow)
);

// File: tb/sim_row_dispatch.sv
module sim_row_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int ROWS = 480;

  logic clk = 1'b0;
  logic rst_n;
  logic [26:0] top_left, step;
  logic [N-1:0] wkr_req, wkr_grant, res_stb, overflow;
  logic [8:0] row_idx, out_row;
  logic [26:0] row_coord;
  logic frame_done, out_stb;
  logic [N*9-1:0] res_row;
  logic [N*10-1:0] res_col;
  logic [N*16-1:0] res_val;
  logic [9:0] out_col;
  logic [15:0] out_val;

  int n_chk = 0;
  int n_err = 0;
  logic [8:0]  exp_row;
  logic [26:0] exp_crd;

  // upper nibble request, lower nibble expected grant
  localparam logic [7:0] ARB_TBL [8] = '{8'h00, 8'h11, 8'hA2, 8'hC4,
                                         8'h88, 8'hF1, 8'h62, 8'h00};

  always #(CLK_PERIOD/2) clk = ~clk;

  row_dispatch #(.N(N), .ROWS(ROWS), .DEPTH(4)) u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input int w, input logic s, input logic [8:0] r,
                     input logic [9:0] c, input logic [15:0] v);
    res_stb[w]        = s;
    res_row[w*9 +: 9]   = r;
    res_col[w*10 +: 10] = c;
    res_val[w*16 +: 16] = v;
  endtask

  task automatic model_adv();
    if (exp_row == 9'(ROWS - 1)) begin
      exp_row = '0;
      exp_crd = top_left;
    end else begin
      exp_row = exp_row + 1'b1;
      exp_crd = exp_crd + step;
    end
  endtask

  task automatic out_is(input string tag, input logic [8:0] r,
                        input logic [9:0] c, input logic [15:0] v);
    chk({tag, " stb"}, 64'(out_stb), 64'd1);
    chk({tag, " rec"}, {out_row, out_col, out_val}, {r, c, v});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    top_left = 27'h7F80000;
    step = 27'h0012345;
    wkr_req = '0;
    res_stb = '0; res_row = '0; res_col = '0; res_val = '0;
    tick(); tick();
    // R1: reset state
    chk("R1 row_idx", 64'(row_idx), 64'd0);
    chk("R1 coord", 64'(row_coord), 64'(top_left));
    chk("R1 out_stb/frame_done/overflow", {out_stb, frame_done, overflow}, '0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk("R1 after release", {row_idx, row_coord}, {9'd0, top_left});
    exp_row = '0;
    exp_crd = top_left;

    // R2/R3: table of request patterns
    for (int k = 0; k < 8; k++) begin
      wkr_req = ARB_TBL[k][7:4];
      #1;
      chk("R2 grant", 64'(wkr_grant), 64'(ARB_TBL[k][3:0]));
      tick();
      if (ARB_TBL[k][3:0] != 0) model_adv();
      chk("R3 row_idx", 64'(row_idx), 64'(exp_row));
      chk("R3 coord", 64'(row_coord), 64'(exp_crd));
    end

    // R3/R4: run to the end of the frame
    wkr_req = 4'b0001;
    while (exp_row != 9'(ROWS - 1)) begin
      tick();
      model_adv();
    end
    chk("R3 last row", 64'(row_idx), 64'(ROWS - 1));
    chk("R3 coord before wrap", 64'(row_coord), 64'(exp_crd));
    chk("R4 no pulse yet", 64'(frame_done), 64'd0);
    tick();
    chk("R4 wrap row", 64'(row_idx), 64'd0);
    chk("R4 wrap coord", 64'(row_coord), 64'(top_left));
    chk("R4 pulse", 64'(frame_done), 64'd1);
    wkr_req = '0;
    tick();
    chk("R4 pulse one cycle", 64'(frame_done), 64'd0);
    chk("R3 hold", {row_idx, row_coord}, {9'd0, top_left});

    // R5/R7: single record
    chk("R7 idle", {out_stb, out_row, out_col, out_val}, '0);
    put(2, 1'b1, 9'd5, 10'd7, 16'hABCD);
    tick();
    put(2, 1'b0, '0, '0, '0);
    out_is("R5 single", 9'd5, 10'd7, 16'hABCD);
    tick();
    chk("R7 drained", {out_stb, out_row, out_col, out_val}, '0);

    // R6: priority and per-worker order
    put(1, 1'b1, 9'd11, 10'd1, 16'h1111);
    put(3, 1'b1, 9'd33, 10'd3, 16'h3333);
    tick();
    put(1, 1'b0, '0, '0, '0);
    put(3, 1'b0, '0, '0, '0);
    out_is("R6 low index first", 9'd11, 10'd1, 16'h1111);
    tick();
    out_is("R6 then high index", 9'd33, 10'd3, 16'h3333);
    tick();
    chk("R7 empty", 64'(out_stb), 64'd0);
    put(0, 1'b1, 9'd1, 10'd100, 16'h00AA);
    tick();
    put(0, 1'b1, 9'd1, 10'd101, 16'h00BB);
    out_is("R6 order first", 9'd1, 10'd100, 16'h00AA);
    tick();
    put(0, 1'b0, '0, '0, '0);
    out_is("R6 order second", 9'd1, 10'd101, 16'h00BB);
    tick();

    // R8: overflow of worker 3 while worker 0 holds the output
    for (int k = 1; k <= 6; k++) begin
      put(0, 1'b1, 9'd2, 10'd0, 16'(100 + k));
      put(3, 1'b1, 9'd3, 10'd0, 16'(k));
      tick();
      if (k == 4) chk("R8 not yet", 64'(overflow), 64'd0);
    end
    put(0, 1'b0, '0, '0, '0);
    put(3, 1'b0, '0, '0, '0);
    chk("R8 flag", 64'(overflow), 64'h8);
    out_is("R8 worker0 last", 9'd2, 10'd0, 16'd106);
    for (int k = 1; k <= 4; k++) begin
      tick();
      out_is("R8 kept", 9'd3, 10'd0, 16'(k));
    end
    tick();
    chk("R8 dropped records absent", 64'(out_stb), 64'd0);
    chk("R8 sticky", 64'(overflow), 64'h8);

    // R1: reset in mid-operation
    wkr_req = 4'b0100;
    tick(); tick();
    rst_n = 1'b0;
    #1;
    chk("R1 async row", 64'(row_idx), 64'd0);
    chk("R1 async coord", 64'(row_coord), 64'(top_left));
    chk("R1 async flags", {overflow, frame_done, out_stb}, '0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule